// File: doc/BRIEF.md
# Serial-Bus Clock Output Enable Configurator

This block is a write-only slave on a two-wire serial bus of the SMBus/I2C kind. Its only job is to set which of thirteen clock outputs run. A fast system clock oversamples the bus clock and data lines. The block finds start and stop conditions, shifts in bytes, and acknowledges each byte by pulling the data line low through an output enable. It never drives the line high.

A frame opens with the slave byte 8'hD2, which is 7-bit address 7'b1101001 followed by the write bit 0. Two bytes follow whose values are ignored, a command byte and a count byte. Up to seven data bytes come after them. The first three data bytes each load part of a 13-bit enable register, and some of their bit positions are unused holes. Every output is the pass-through reference clock ANDed with its enable bit, so a disabled output is held low.

Top module: `smb_clkgate_cfg`

## Requirements
- R1: After a synchronous active-low reset, all 13 enable bits are 1 and the block does not pull the data line.
- R2: A frame whose first byte after a start condition is 8'hD2 is acknowledged. Bits arrive most significant first and are sampled on rising bus-clock edges.
- R3: The block acknowledges by pulling the data line low for the whole ninth bus-clock pulse of every byte in an accepted frame. It releases the line after that pulse falls, and never drives it high.
- R4: If the first byte is not 8'hD2, no byte is acknowledged and no enable bit changes until the next start condition.
- R5: The second and third bytes of an accepted frame (command and count) are acknowledged and their values have no effect.
- R6: Data byte 0: bit 7 sets enable 5, bit 6 sets enable 4, bits 3..0 set enables 3..0, and bits 5 and 4 have no effect.
- R7: Data byte 1: bits 7..4 set enables 11..8, bits 1..0 set enables 7..6, and bits 3 and 2 have no effect.
- R8: Data byte 2 bit 6 sets enable 12 and its other bits have no effect. Data bytes 3 to 6, and any byte after data byte 6, are acknowledged and change nothing.
- R9: A data byte takes effect once its eighth bit is received, even if the frame then ends early with a stop condition.
- R10: A start condition inside a frame, or after a rejected address, restarts decoding at the address byte.
- R11: `clk_out[i]` equals `ref_clk` while enable i is 1 and is 0 while enable i is 0.
- R12: A stop condition ends the frame and releases the data line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_pull | output | 1 | 1 pulls the data line low (open-drain enable) |
| ref_clk | input | 1 | Clock that is passed through to enabled outputs |
| clk_out | output | 13 | Gated copies of ref_clk |
| out_en | output | 13 | Current enable vector |

## Verification
The bench sweeps data bytes over many bit patterns and checks each mapped field. A wrong bit position would enable the wrong output, and a write into a reserved hole would show up as a change in an unrelated enable. Wrong slave bytes, including the 8'hD3 read variant, are sent with data behind them; a block that compared too few address bits would acknowledge them and rewrite its enables. Frames cut short after one data byte, frames longer than seven data bytes, and repeated starts in mid-frame are also tested. A sequencer that counted bytes wrongly across a restart would load data into the wrong register or leave an acknowledge stuck low.

// File: rtl/cgc_pkg.sv
// Shared constants and types for the serial clock-enable configurator.
package cgc_pkg;
    localparam int NUM_OUT    = 13;  // gated clock outputs
    localparam int PRE_BYTES  = 3;   // address, command, count
    localparam int DATA_BYTES = 7;   // data bytes that form a full frame
    localparam int MAP_BYTES  = 3;   // data bytes that carry enable fields

    typedef enum logic [2:0] {
        SQ_IDLE,     // no frame open
        SQ_BITS,     // shifting in bits of a byte
        SQ_ACKWAIT,  // byte done, waiting for bus clock to fall
        SQ_ACK,      // pulling data low for the ninth pulse
        SQ_SKIP      // address rejected, waiting for a start
    } seq_state_t;
endpackage

// File: rtl/cgc_line_sync.sv
// Synchronizes the two bus lines into the system clock domain and
// flags bus-clock edges plus start and stop conditions.
// Assumes each bus level lasts several system clock cycles.
module cgc_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_d;
    logic              sda_d;

    // Synchronizer chains, idle-high reset value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
        end else begin
            scl_chain <= {scl_chain[STAGES-2:0], scl_in};
            sda_chain <= {sda_chain[STAGES-2:0], sda_in};
        end
    end

    assign scl_q = scl_chain[STAGES-1];
    assign sda_q = sda_chain[STAGES-1];

    // One-cycle-delayed copies for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_q;
            sda_d <= sda_q;
        end
    end

    // Edge and condition decode
    always_comb begin
        scl_rise  = scl_q & ~scl_d;
        scl_fall  = ~scl_q & scl_d;
        start_det = scl_q & scl_d & sda_d & ~sda_q;
        stop_det  = scl_q & scl_d & ~sda_d & sda_q;
    end
endmodule

// File: rtl/cgc_frame_seq.sv
// Walks through the write frame: shifts bytes in MSB first, checks the
// slave byte, schedules the acknowledge and emits one write pulse per
// completed data byte. Assumes synchronized inputs from cgc_line_sync.
module cgc_frame_seq
    import cgc_pkg::*;
#(
    parameter logic [7:0] SLAVE_BYTE = 8'hD2,
    parameter int         IDX_W      = $clog2(PRE_BYTES + DATA_BYTES + 1),
    parameter int         DIDX_W     = $clog2(DATA_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_q,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [DIDX_W-1:0] wr_idx,
    output logic [7:0]        wr_data
);
    localparam logic [IDX_W-1:0] FIRST_DATA = IDX_W'(PRE_BYTES);
    localparam logic [IDX_W-1:0] END_DATA   = IDX_W'(PRE_BYTES + DATA_BYTES);

    seq_state_t       state;
    logic [2:0]       bit_cnt;
    logic [6:0]       shreg;
    logic [IDX_W-1:0] byte_idx;
    logic [7:0]       byte_now;
    logic             is_data;

    // Byte as it stands once the current bit is shifted in
    always_comb begin
        byte_now = {shreg, sda_q};
        is_data  = (byte_idx >= FIRST_DATA) && (byte_idx < END_DATA);
    end

    // Frame state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            byte_idx <= '0;
            sda_oe   <= 1'b0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state    <= SQ_BITS;
                bit_cnt  <= '0;
                byte_idx <= '0;
                sda_oe   <= 1'b0;
            end else if (stop_det) begin
                state  <= SQ_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    SQ_BITS: if (scl_rise) begin
                        shreg   <= byte_now[6:0];
                        bit_cnt <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7) begin
                            if (byte_idx == '0 && byte_now != SLAVE_BYTE) begin
                                state <= SQ_SKIP;
                            end else begin
                                state <= SQ_ACKWAIT;
                                if (is_data) begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= DIDX_W'(byte_idx - FIRST_DATA);
                                    wr_data <= byte_now;
                                end
                            end
                        end
                    end
                    SQ_ACKWAIT: if (scl_fall) begin
                        sda_oe <= 1'b1;
                        state  <= SQ_ACK;
                    end
                    SQ_ACK: if (scl_fall) begin
                        sda_oe  <= 1'b0;
                        state   <= SQ_BITS;
                        bit_cnt <= '0;
                        if (byte_idx != END_DATA) byte_idx <= byte_idx + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/cgc_enable_map.sv
// Holds the enable register and scatters each data byte's fields onto
// it. Data indices beyond the mapped bytes are dropped.
module cgc_enable_map
    import cgc_pkg::*;
#(
    parameter int DIDX_W = $clog2(DATA_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [DIDX_W-1:0]  wr_idx,
    input  logic [7:0]         wr_data,
    output logic [NUM_OUT-1:0] en_q
);
    // Field loads per data byte; reserved positions are not read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '1;
        end else if (wr_en) begin
            case (wr_idx)
                DIDX_W'(0): begin
                    en_q[5]   <= wr_data[7];
                    en_q[4]   <= wr_data[6];
                    en_q[3:0] <= wr_data[3:0];
                end
                DIDX_W'(1): begin
                    en_q[11:8] <= wr_data[7:4];
                    en_q[7:6]  <= wr_data[1:0];
                end
                DIDX_W'(2): begin
                    en_q[12] <= wr_data[6];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cgc_out_gate.sv
// ANDs the reference clock with each enable bit, so a disabled output
// stays low. Assumes enables change rarely compared with the reference.
module cgc_out_gate #(
    parameter int WIDTH = 13
) (
    input  logic             ref_clk,
    input  logic [WIDTH-1:0] en,
    output logic [WIDTH-1:0] clk_out
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_gate
        // Per-output gate
        assign clk_out[g] = ref_clk & en[g];
    end
endmodule

// File: rtl/smb_clkgate_cfg.sv
// Top level: bus front end, frame sequencer, enable register and output
// gates. The data line is only ever pulled low through sda_pull.
module smb_clkgate_cfg
    import cgc_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] SLAVE_BYTE  = 8'hD2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_pull,
    input  logic               ref_clk,
    output logic [NUM_OUT-1:0] clk_out,
    output logic [NUM_OUT-1:0] out_en
);
    localparam int DIDX_W = $clog2(DATA_BYTES);

    logic              scl_q;
    logic              sda_q;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              wr_en;
    logic [DIDX_W-1:0] wr_idx;
    logic [7:0]        wr_data;

    cgc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    cgc_frame_seq #(.SLAVE_BYTE(SLAVE_BYTE), .DIDX_W(DIDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .sda_q(sda_q), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .sda_oe(sda_pull), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    cgc_enable_map #(.DIDX_W(DIDX_W)) u_map (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .en_q(out_en)
    );

    cgc_out_gate #(.WIDTH(NUM_OUT)) u_gate (
        .ref_clk(ref_clk), .en(out_en), .clk_out(clk_out)
    );

    logic unused_scl;
    assign unused_scl = scl_q;
endmodule

// File: rtl/cgc_checker.sv
// Timing properties of the configurator, bound into the top module.
module cgc_checker #(
    parameter int W = 13
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sda_oe,
    input logic [W-1:0] out_en,
    input logic         scl_fall,
    input logic         start_det,
    input logic         stop_det,
    input logic         wr_en
);
    // R3: the acknowledge only begins after a bus-clock fall
    a_r3_ack_starts_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

    // R3: the acknowledge ends only on a fall, start or stop
    a_r3_ack_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> $past(scl_fall || start_det || stop_det));

    // R12: a stop releases the line on the next cycle
    a_r12_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R4: enables change only as the result of a write pulse
    a_r4_en_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(out_en));

    // R9: one write pulse per received byte
    a_r9_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
endmodule

bind smb_clkgate_cfg cgc_checker #(.W(cgc_pkg::NUM_OUT)) i_cgc_checker (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_pull), .out_en(out_en),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .wr_en(wr_en)
);

// File: tb/test_smb_clkgate_cfg.sv
`timescale 1ns/1ps
module test_smb_clkgate_cfg;
    localparam int HALF = 12;
    localparam int Q    = HALF / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        ref_clk = 1'b0;
    logic        sda_pull;
    logic [12:0] clk_out;
    logic [12:0] out_en;
    logic        sda_line;
    logic [12:0] exp_en;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    assign sda_line = sda_m & ~sda_pull;

    always #4 clk = ~clk;

    smb_clkgate_cfg i_smb_clkgate_cfg (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_pull(sda_pull), .ref_clk(ref_clk), .clk_out(clk_out),
        .out_en(out_en)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected effect of a data byte, written from R6..R8
    function automatic logic [12:0] model(input logic [12:0] cur, input int idx, input logic [7:0] d);
        logic [12:0] r = cur;
        if (idx == 0) begin
            r[5] = d[7]; r[4] = d[6];
            for (int k = 0; k < 4; k++) r[k] = d[k];
        end else if (idx == 1) begin
            for (int k = 0; k < 4; k++) r[8+k] = d[4+k];
            r[7] = d[1]; r[6] = d[0];
        end else if (idx == 2) begin
            r[12] = d[6];
        end
        return r;
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; wait_cyc(Q);
        scl_m = 1'b1; wait_cyc(HALF);
        sda_m = 1'b0; wait_cyc(HALF);
        scl_m = 1'b0; wait_cyc(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_cyc(Q);
        scl_m = 1'b1; wait_cyc(HALF);
        sda_m = 1'b1; wait_cyc(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_cyc(Q);
            scl_m = 1'b1; wait_cyc(HALF);
            scl_m = 1'b0; wait_cyc(Q);
        end
        sda_m = 1'b1; wait_cyc(Q);
        scl_m = 1'b1; wait_cyc(Q);
        acked = (sda_line == 1'b0);
        wait_cyc(Q);
        scl_m = 1'b0; wait_cyc(Q);
    endtask

    // Sends start, the slave byte and n further bytes; checks acks, updates model
    task automatic frame(input logic [7:0] a, input int n, input logic [7:0] b[13], input bit stop);
        logic ack;
        bit   ok = (a == 8'hD2);
        bus_start();
        send_byte(a, ack);
        chk(ok ? "R2 address ack" : "R4 mismatch no ack", ack, ok);
        for (int k = 0; k < n; k++) begin
            send_byte(b[k], ack);
            chk(ok ? "R3/R5/R8 byte ack" : "R4 no ack after mismatch", ack, ok);
            if (ok) exp_en = model(exp_en, k - 2, b[k]);
        end
        if (stop) bus_stop();
        wait_cyc(4);
    endtask

    task automatic check_outputs(input string req);
        chk(req, out_en, exp_en);
        chk("R3 line released", sda_pull, 0);
        ref_clk = 1'b1; wait_cyc(1);
        chk("R11 gated outputs follow high", clk_out, exp_en);
        ref_clk = 1'b0; wait_cyc(1);
        chk("R11 gated outputs low", clk_out, 0);
    endtask

    initial begin
        logic [7:0] b[13];
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(3);
        exp_en = 13'h1FFF;
        check_outputs("R1 reset enables");

        // All fields cleared, then all set
        b = '{default: 8'h00};
        frame(8'hD2, 5, b, 1'b1);
        check_outputs("R6 R7 R8 clear all");
        chk("R6 R7 R8 all off", out_en, 0);
        b = '{default: 8'hFF};
        frame(8'hD2, 5, b, 1'b1);
        check_outputs("R6 R7 R8 set all");

        // Sweep of data patterns over the three mapped bytes
        for (int i = 0; i < 48; i++) begin
            b = '{default: 8'h00};
            b[0] = 8'(i * 91 + 17);
            b[1] = 8'(i * 13 + 200);
            b[2] = 8'(i * 73 + 5);
            b[3] = 8'(i * 37);
            b[4] = 8'(i * 151 + 3);
            b[5] = 8'(i * 29 + 1);
            frame(8'hD2, 6, b, 1'b1);
            check_outputs("R6 R7 R8 R5 sweep");
        end

        // Wrong slave bytes: no ack, nothing changes
        begin
            logic [7:0] bad[4] = '{8'hD3, 8'h52, 8'hD0, 8'h92};
            for (int j = 0; j < 4; j++) begin
                b = '{default: 8'h5A};
                b[2] = ~exp_en[7:0]; b[3] = ~exp_en[7:0];
                frame(bad[j], 5, b, 1'b1);
                check_outputs("R4 mismatch keeps enables");
            end
        end

        // Long frame: all data bytes plus extras acked, only first three act
        b = '{default: 8'hFF};
        b[2] = 8'h0F; b[3] = 8'h00; b[4] = 8'h00;
        frame(8'hD2, 13, b, 1'b1);
        check_outputs("R8 extra bytes ignored");

        // Early stop after data byte 0
        b = '{default: 8'h00};
        b[2] = 8'h30;
        frame(8'hD2, 3, b, 1'b1);
        check_outputs("R9 partial frame");

        // Repeated start mid-frame: decoding restarts at address byte
        b = '{default: 8'h00};
        b[2] = 8'hFF; b[3] = 8'h00;
        frame(8'hD2, 3, b, 1'b0);
        b = '{default: 8'h00};
        b[2] = 8'h81;
        frame(8'hD2, 3, b, 1'b1);
        check_outputs("R10 repeated start");

        // Rejected address then a start without stop: valid frame works
        b = '{default: 8'hFF};
        frame(8'hD3, 4, b, 1'b0);
        b = '{default: 8'hFF};
        frame(8'hD2, 5, b, 1'b1);
        check_outputs("R10 restart after mismatch");

        // Stop leaves the line idle
        wait_cyc(20);
        chk("R12 idle after stop", sda_pull, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule